// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block sits between a handful of interrupt request flags and a processor core. Each source has a priority bit that puts it at the high or the low level. The block picks the request the core should service next. When two requests wait at the same level, the one with the lower source index wins. The winner is offered to the core as a source index, its level, and a one-cycle valid pulse. The core's acknowledge pulse marks that level as in service. Two in-service bits, one per level, let a high-level request interrupt a low-level handler. They also block everything while a high-level handler runs.

The priority bits can be rewritten at any time. A return strobe frees the innermost active level, and arbitration runs again at once against the current flags and priority bits. A handler can use this to move itself to the low level. It leaves its own flag set, clears its priority bit and returns. The controller then hands the same source straight back at the low level, where any high-level request can interrupt it.

The controller is one state machine with three states. ST_SCAN arbitrates every cycle. The transition *offer* (global enable set and a request eligible) leads to ST_OFFER, which drives the valid pulse for one cycle. From ST_OFFER, *take* (acknowledge present) returns to ST_SCAN, and *stall* (no acknowledge) leads to ST_HOLD. From ST_HOLD, *take* returns to ST_SCAN. The return strobe works in every state and does not change the state.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both in-service bits are clear and no grant is issued. A low-level request that is pending when reset is released is granted without any return strobe.
- R2: While `glb_en` is low, no grant is issued. A request that is pending when `glb_en` rises is then granted.
- R3: When no handler is in service, any eligible request whose priority bit is 1 (high level) is granted ahead of every request whose bit is 0 (low level), whatever their indices.
- R4: Among pending requests at the same level, the lowest source index is granted first. A priority bit has no effect on arbitration while its request flag is 0.
- R5: A grant drives `grant_valid` high for exactly one cycle. During that cycle `grant_idx` holds the winning index and `grant_lvl` holds its level (1 = high). An `ack` during that cycle or any later cycle before the next arbitration sets the in-service bit for that level.
- R6: While only the low in-service bit is set, low-level requests are not granted and high-level requests are granted, which pre-empts the low handler.
- R7: While the high in-service bit is set, no request is granted at either level.
- R8: A return strobe clears the high in-service bit if it is set, and leaves the low bit unchanged. Otherwise it clears the low bit.
- R9: A request still flagged when its handler returns is granted again right after the return, at the level its priority bit holds at that time.
- R10: A source moved down to the low level by R9 can be pre-empted by any high-level request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| req_flags | input | N_SRC | Request flag per source, bit i = source i |
| prio_hi | input | N_SRC | Priority register, 1 = high level |
| ack | input | 1 | Core acknowledges the offered grant |
| ret | input | 1 | Return-from-interrupt strobe |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_idx | output | IDX_W | Index of the granted source |
| grant_lvl | output | 1 | Level of the granted source, 1 = high |

## Verification
The case hardest to reach from the ports is a nested stack: the low in-service bit set under a set high bit, with both kinds of request still pending. The first return must then free only the upper level. The bench reaches this state by acknowledging a low grant, raising a high request, and acknowledging that too. It keeps low requests pending, so a wrong clear shows up as a grant that should not happen. The move down to the low level is reached the same way a handler would reach it. The bench keeps the flag set, rewrites the priority bit and returns. It then pre-empts the re-granted source with a fresh high request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HOLD  = 2'd2
    } irqc_state_e;

    localparam logic LVL_LO = 1'b0;
    localparam logic LVL_HI = 1'b1;

endpackage

// File: rtl/irqc_first.sv
// Lowest-index set-bit finder: the fixed scan order within one level.
module irqc_first #(
    parameter int N_SRC = 5,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqc_level_track.sv
// Per-level in-service bits: set on acknowledge, innermost cleared on return.
module irqc_level_track (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_lvl,
    input  logic ret,
    output logic isr_hi,
    output logic isr_lo
);
    logic hi_nxt, lo_nxt;

    always_comb begin
        hi_nxt = isr_hi;
        lo_nxt = isr_lo;
        if (ret) begin
            if (isr_hi) hi_nxt = 1'b0;
            else        lo_nxt = 1'b0;
        end
        if (take) begin
            if (take_lvl) hi_nxt = 1'b1;
            else          lo_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_hi <= 1'b0;
            isr_lo <= 1'b0;
        end else begin
            isr_hi <= hi_nxt;
            isr_lo <= lo_nxt;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC = 5,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic [N_SRC-1:0] req_flags,
    input  logic [N_SRC-1:0] prio_hi,
    input  logic             ack,
    input  logic             ret,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_lvl
);
    irqc_state_e      state, state_nxt;
    logic [N_SRC-1:0] req_q, prio_q;
    logic [IDX_W-1:0] cap_idx;
    logic             cap_lvl;
    logic             isr_hi, isr_lo;
    logic             hit_hi, hit_lo;
    logic [IDX_W-1:0] idx_hi, idx_lo;
    logic             allow_hi, allow_lo;
    logic             win, win_lvl, take;
    logic [IDX_W-1:0] win_idx;

    // Level-split request vectors, scanned independently.
    irqc_first #(.N_SRC(N_SRC)) u_find_hi (
        .vec (req_q & prio_q),
        .hit (hit_hi),
        .idx (idx_hi)
    );

    irqc_first #(.N_SRC(N_SRC)) u_find_lo (
        .vec (req_q & ~prio_q),
        .hit (hit_lo),
        .idx (idx_lo)
    );

    irqc_level_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_lvl (cap_lvl),
        .ret      (ret),
        .isr_hi   (isr_hi),
        .isr_lo   (isr_lo)
    );

    // Eligibility per level from the in-service stack.
    always_comb begin
        allow_hi = !isr_hi;
        allow_lo = !isr_hi && !isr_lo;
        win      = 1'b0;
        win_lvl  = LVL_LO;
        win_idx  = idx_lo;
        if (allow_hi && hit_hi) begin
            win     = 1'b1;
            win_lvl = LVL_HI;
            win_idx = idx_hi;
        end else if (allow_lo && hit_lo) begin
            win = 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SCAN:  if (glb_en && win) state_nxt = ST_OFFER;
            ST_OFFER: state_nxt = ack ? ST_SCAN : ST_HOLD;
            ST_HOLD:  if (ack) state_nxt = ST_SCAN;
            default:  state_nxt = ST_SCAN;
        endcase
    end

    // State register, input sampling and grant capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SCAN;
            req_q   <= '0;
            prio_q  <= '0;
            cap_idx <= '0;
            cap_lvl <= LVL_LO;
        end else begin
            state  <= state_nxt;
            req_q  <= req_flags;
            prio_q <= prio_hi;
            if (state == ST_SCAN && state_nxt == ST_OFFER) begin
                cap_idx <= win_idx;
                cap_lvl <= win_lvl;
            end
        end
    end

    // Outputs.
    always_comb begin
        grant_valid = (state == ST_OFFER);
        grant_idx   = cap_idx;
        grant_lvl   = cap_lvl;
        take        = ack && (state != ST_SCAN);
    end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
    parameter int N_SRC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic glb_en,
    input logic ack,
    input logic ret,
    input logic grant_valid,
    input logic grant_lvl,
    input logic isr_hi,
    input logic isr_lo
);
    AST_NO_GRANT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(glb_en)); // R2

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid); // R5

    AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && ack && !ret) |=> ($past(grant_lvl) ? isr_hi : isr_lo)); // R5

    AST_LOW_BUSY_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && isr_lo) |-> grant_lvl); // R6

    AST_HIGH_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !isr_hi); // R7

    AST_RET_POPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && isr_hi && !ack) |=> !isr_hi); // R8

    AST_RET_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && isr_hi && !ack) |=> (isr_lo == $past(isr_lo))); // R8
endmodule

bind irq_prio_ctrl irqc_checks #(.N_SRC(N_SRC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en      (glb_en),
    .ack         (ack),
    .ret         (ret),
    .grant_valid (grant_valid),
    .grant_lvl   (grant_lvl),
    .isr_hi      (isr_hi),
    .isr_lo      (isr_lo)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    localparam int N = 5;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glb_en = 1'b0;
    logic [N-1:0]  req_flags = '0;
    logic [N-1:0]  prio_hi = '0;
    logic          ack = 1'b0;
    logic          ret = 1'b0;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;
    logic          grant_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(.N_SRC(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .glb_en      (glb_en),
        .req_flags   (req_flags),
        .prio_hi     (prio_hi),
        .ack         (ack),
        .ret         (ret),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_lvl   (grant_lvl)
    );

    // {req[4:0], prio[4:0], expected idx[2:0], expected lvl}
    localparam logic [13:0] VECS [0:7] = '{
        {5'b00001, 5'b00000, 3'd0, 1'b0},
        {5'b10000, 5'b00000, 3'd4, 1'b0},
        {5'b11010, 5'b00000, 3'd1, 1'b0},
        {5'b00011, 5'b00010, 3'd1, 1'b1},
        {5'b11111, 5'b10100, 3'd2, 1'b1},
        {5'b11000, 5'b11000, 3'd3, 1'b1},
        {5'b10001, 5'b10000, 3'd4, 1'b1},
        {5'b01110, 5'b00001, 3'd1, 1'b0}
    };

    task automatic check(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wait_grant(input int lim, output int got, output int idx, output int lvl);
        got = 0; idx = -1; lvl = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (grant_valid) begin
                got = 1; idx = int'(grant_idx); lvl = int'(grant_lvl);
                break;
            end
        end
    endtask

    task automatic count_grants(input int cyc, output int cnt);
        cnt = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (grant_valid) cnt++;
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_ret();
        ret = 1'b1; @(negedge clk); ret = 1'b0;
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int got, idx, lvl, cnt;

        // R1: quiet during and right after reset
        idle(3);
        check("R1 valid in reset", int'(grant_valid), 0);
        rst_n = 1'b1;
        glb_en = 1'b1;
        count_grants(5, cnt);
        check("R1 no grant without request", cnt, 0);

        // R3/R4: arbitration table from the idle stack
        foreach (VECS[v]) begin
            req_flags = VECS[v][13:9];
            prio_hi   = VECS[v][8:4];
            wait_grant(6, got, idx, lvl);
            check($sformatf("R3/R4 vec%0d grant", v), got, 1);
            check($sformatf("R4 vec%0d idx", v), idx, int'(VECS[v][3:1]));
            check($sformatf("R3 vec%0d lvl", v), lvl, int'(VECS[v][0]));
            pulse_ack();
            req_flags = '0;
            idle(2);
            pulse_ret();
            idle(2);
        end
        prio_hi = '0;

        // R2: global enable gates grants
        glb_en = 1'b0;
        req_flags = 5'b00100;
        count_grants(6, cnt);
        check("R2 no grant while disabled", cnt, 0);
        glb_en = 1'b1;
        wait_grant(6, got, idx, lvl);
        check("R2 grant after enable", got, 1);
        check("R2 idx", idx, 2);
        // R5: pulse width, then late ack from hold
        @(negedge clk);
        check("R5 pulse is one cycle", int'(grant_valid), 0);
        idle(2);
        pulse_ack();
        req_flags = '0;
        idle(2);
        pulse_ret();
        idle(2);

        // R6/R7/R8: nested in-service stack
        req_flags = 5'b01000;
        wait_grant(6, got, idx, lvl);
        check("R6 low grant idx", idx, 3);
        pulse_ack();
        req_flags = 5'b01001;
        count_grants(6, cnt);
        check("R6 low blocked under low", cnt, 0);
        prio_hi = 5'b10000;
        req_flags = 5'b11001;
        wait_grant(6, got, idx, lvl);
        check("R6 high pre-empts", got, 1);
        check("R6 idx", idx, 4);
        check("R6 lvl", lvl, 1);
        pulse_ack();
        prio_hi = 5'b10100;
        req_flags = 5'b01101;
        count_grants(6, cnt);
        check("R7 nothing under high", cnt, 0);
        req_flags = 5'b01001;
        idle(2);
        pulse_ret();
        count_grants(6, cnt);
        check("R8 first return keeps low", cnt, 0);
        pulse_ret();
        wait_grant(6, got, idx, lvl);
        check("R8 second return frees low", got, 1);
        check("R8 idx", idx, 0);
        check("R8 lvl", lvl, 0);
        pulse_ack();
        req_flags = '0;
        prio_hi = '0;
        idle(2);
        pulse_ret();
        idle(2);

        // R9/R10: handler moves itself down a level
        prio_hi = 5'b00010;
        req_flags = 5'b00010;
        wait_grant(6, got, idx, lvl);
        check("R9 initial high lvl", lvl, 1);
        pulse_ack();
        prio_hi = 5'b00000;
        idle(2);
        pulse_ret();
        wait_grant(6, got, idx, lvl);
        check("R9 re-grant", got, 1);
        check("R9 re-grant idx", idx, 1);
        check("R9 re-grant at low", lvl, 0);
        pulse_ack();
        prio_hi = 5'b10000;
        req_flags = 5'b10010;
        wait_grant(6, got, idx, lvl);
        check("R10 pre-empt moved handler", got, 1);
        check("R10 idx", idx, 4);
        pulse_ack();
        req_flags = 5'b00010;
        idle(2);
        pulse_ret();
        count_grants(4, cnt);
        check("R10 low still busy", cnt, 0);
        req_flags = '0;
        idle(2);
        pulse_ret();
        prio_hi = '0;
        idle(2);

        // R1: reset clears a held low in-service bit
        req_flags = 5'b00100;
        wait_grant(6, got, idx, lvl);
        pulse_ack();
        idle(2);
        rst_n = 1'b0;
        idle(2);
        check("R1 valid low in reset", int'(grant_valid), 0);
        rst_n = 1'b1;
        wait_grant(6, got, idx, lvl);
        check("R1 grant after reset", got, 1);
        check("R1 idx after reset", idx, 2);

        done = 1;
        summary();
        $finish;
    end
endmodule